// File: doc/BRIEF.md
# Cascadable 16-bit Microprogrammed ALU Slice

This block is one 16-bit slice of a bit-slice datapath. A 9-bit microword is applied each cycle. Its low field picks the operand pair R and S from the register file ports, the Q register, the external data input or zero. Its middle field picks one of eight ALU functions. Its high field picks where the result goes and whether it is shifted on the way. The register file has sixteen 16-bit words and two read ports. The A address reads only. The B address reads and also names the word that is written.

The read ports pass through level-sensitive latches. These are open while the clock is high and closed while it is low, so the operands stay fixed through the low phase. A register write and a Q load both take effect on the rising clock edge. Four bidirectional shift-end pins carry the bit that leaves or enters the register path and the Q path during a shift. A wider word is built by tying these pins, and the carry, between neighbouring slices. The Y output can be released to high impedance.

Top module: `alu_slice16`

## Requirements
- R1: An active-low asynchronous reset clears the Q register and all sixteen register words to zero.
- R2: Microword bits [2:0] choose (R,S): 0=(A,Q), 1=(A,B), 2=(0,Q), 3=(0,B), 4=(0,A), 5=(D,A), 6=(D,Q), 7=(D,0). Here A and B are the register words at the A and B addresses, and D is the data input.
- R3: Microword bits [5:3] codes 0, 1 and 2 compute R+S+cin, S+~R+cin and R+~S+cin. The carry out of bit 15 appears on `cout`.
- R4: Codes 3 to 7 of bits [5:3] compute R|S, R&S, ~R&S, R^S and ~(R^S).
- R5: `ovf` is the XOR of the carry into bit 15 and the carry out of bit 15. The logic functions report `cout`=0 and `ovf`=0.
- R6: `zero` is high exactly when all 16 bits of the ALU result F are 0. `neg` equals F[15]. Both follow F even when Y shows A.
- R7: Microword bits [8:6] codes 0 to 3: code 0 loads F into Q, code 1 loads nothing, and codes 2 and 3 write F into word B. Y shows F for every code except 2, where Y shows A.
- R8: Code 4 writes F shifted right into word B and Q shifted right into Q. Code 5 does only the register part. The new MSBs are read from `ram_msb` and `q_msb`. The slice drives F[0] on `ram_lsb` and Q[0] on `q_lsb`.
- R9: Code 6 writes F shifted left into word B and Q shifted left into Q. Code 7 does only the register part. The new LSBs are read from `ram_lsb` and `q_lsb`. The slice drives F[15] on `ram_msb` and Q[15] on `q_msb`.
- R10: For codes 0 to 3 the slice drives none of the four shift-end pins.
- R11: Both addresses read in the same cycle. A write changes only the word at B, whatever A holds.
- R12: When `out_en` is 0, Y is high impedance. When it is 1, Y is driven.
- R13: A change of `addr_a` or `addr_b` while the clock is low does not reach the operands until the clock next goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge updates Q and the register file |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 9 | Microword: [8:6] destination, [5:3] function, [2:0] source |
| addr_a | input | 4 | Read-only register address |
| addr_b | input | 4 | Read and write register address |
| d_in | input | 16 | External data operand |
| cin | input | 1 | Carry into bit 0 |
| ram_lsb | inout | 1 | Register-path shift end, low side |
| ram_msb | inout | 1 | Register-path shift end, high side |
| q_lsb | inout | 1 | Q-path shift end, low side |
| q_msb | inout | 1 | Q-path shift end, high side |
| out_en | input | 1 | Y drive enable, active high |
| y | output | 16 | Result output (F, or A for destination code 2) |
| cout | output | 1 | Carry out of bit 15 |
| ovf | output | 1 | Signed overflow |
| zero | output | 1 | F is all zeros |
| neg | output | 1 | F[15] |

## Verification
Y, the four flags and the shift-end pins settle in the same cycle in which the microword is applied. The bench drives each microword just after a rising edge and samples these results in the following low phase. A register write or a Q load lands on the next rising edge. Each one is therefore checked by a read-back microword in the following cycle and is never looked for earlier. The latch check moves an address during the low phase and expects the old operand until the clock has gone high again.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

  typedef enum logic [2:0] {
    SRC_AQ = 3'd0, SRC_AB = 3'd1, SRC_ZQ = 3'd2, SRC_ZB = 3'd3,
    SRC_ZA = 3'd4, SRC_DA = 3'd5, SRC_DQ = 3'd6, SRC_DZ = 3'd7
  } src_sel_e;

  typedef enum logic [2:0] {
    FN_ADD  = 3'd0, FN_SUBR = 3'd1, FN_SUBS = 3'd2, FN_OR  = 3'd3,
    FN_AND  = 3'd4, FN_NRAS = 3'd5, FN_XOR  = 3'd6, FN_XNOR = 3'd7
  } alu_fn_e;

  typedef enum logic [2:0] {
    DST_QREG  = 3'd0, DST_NOP   = 3'd1, DST_RAM_A = 3'd2, DST_RAM_F = 3'd3,
    DST_DN_RQ = 3'd4, DST_DN_R  = 3'd5, DST_UP_RQ = 3'd6, DST_UP_R  = 3'd7
  } dst_sel_e;

  typedef struct packed {
    logic cout;
    logic ovf;
    logic zero;
    logic neg;
  } alu_flags_t;

endpackage

// File: rtl/alu_slice_regfile.sv
module alu_slice_regfile #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // write port: B address only, rising edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[addr_b] <= wr_data;
    end
  end

  // read latches: open while clk is high, closed while low
  always_latch begin
    if (clk) begin
      rd_a <= mem[addr_a];
      rd_b <= mem[addr_b];
    end
  end

  // R11
  ram_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(addr_b)] == $past(wr_data));

  // R11
  ram_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr_a != addr_b)) |=> mem[$past(addr_a)] == $past(rd_a));

endmodule

// File: rtl/alu_slice_alu.sv
module alu_slice_alu
  import alu_slice_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  src_sel_e          src_sel,
  input  alu_fn_e           fn_sel,
  input  logic [DATA_W-1:0] a_op,
  input  logic [DATA_W-1:0] b_op,
  input  logic [DATA_W-1:0] q_op,
  input  logic [DATA_W-1:0] d_op,
  input  logic              cin,
  output logic [DATA_W-1:0] f,
  output alu_flags_t        flags
);
  localparam int MSB = DATA_W - 1;

  function automatic logic [DATA_W:0] add_full(logic [MSB:0] x, logic [MSB:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + (DATA_W+1)'(c);
  endfunction

  function automatic logic carry_into_msb(logic [MSB:0] x, logic [MSB:0] y, logic c);
    logic [MSB:0] low_sum;
    low_sum = {1'b0, x[MSB-1:0]} + {1'b0, y[MSB-1:0]} + DATA_W'(c);
    return low_sum[MSB];
  endfunction

  function automatic logic [MSB:0] logic_op(alu_fn_e fn, logic [MSB:0] r, logic [MSB:0] s);
    case (fn)
      FN_OR:   return r | s;
      FN_AND:  return r & s;
      FN_NRAS: return ~r & s;
      FN_XOR:  return r ^ s;
      default: return ~(r ^ s);
    endcase
  endfunction

  logic [MSB:0]  r_op, s_op;
  logic [MSB:0]  add_x, add_y;
  logic [DATA_W:0] add_sum;
  logic          msb_carry_in;
  logic          is_arith;

  always_comb begin
    case (src_sel)
      SRC_AQ:  begin r_op = a_op; s_op = q_op; end
      SRC_AB:  begin r_op = a_op; s_op = b_op; end
      SRC_ZQ:  begin r_op = '0;   s_op = q_op; end
      SRC_ZB:  begin r_op = '0;   s_op = b_op; end
      SRC_ZA:  begin r_op = '0;   s_op = a_op; end
      SRC_DA:  begin r_op = d_op; s_op = a_op; end
      SRC_DQ:  begin r_op = d_op; s_op = q_op; end
      default: begin r_op = d_op; s_op = '0;   end
    endcase
  end

  always_comb begin
    case (fn_sel)
      FN_SUBR: begin add_x = s_op; add_y = ~r_op; end
      FN_SUBS: begin add_x = r_op; add_y = ~s_op; end
      default: begin add_x = r_op; add_y = s_op;  end
    endcase
    is_arith     = (fn_sel == FN_ADD) || (fn_sel == FN_SUBR) || (fn_sel == FN_SUBS);
    add_sum      = add_full(add_x, add_y, cin);
    msb_carry_in = carry_into_msb(add_x, add_y, cin);
    f            = is_arith ? add_sum[MSB:0] : logic_op(fn_sel, r_op, s_op);
    flags.cout   = is_arith & add_sum[DATA_W];
    flags.ovf    = is_arith & (add_sum[DATA_W] ^ msb_carry_in);
    flags.zero   = (f == '0);
    flags.neg    = f[MSB];
  end

  // R5
  logic_flags_chk: assert property (@(negedge clk) disable iff (!rst_n)
    !is_arith |-> (!flags.cout && !flags.ovf));

  // R5
  ovf_sign_chk: assert property (@(negedge clk) disable iff (!rst_n)
    flags.ovf |-> ((add_x[MSB] == add_y[MSB]) && (f[MSB] != add_x[MSB])));

endmodule

// File: rtl/alu_slice_dest.sv
module alu_slice_dest
  import alu_slice_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dst_sel_e          dst_sel,
  input  logic [DATA_W-1:0] f,
  input  logic [DATA_W-1:0] a_op,
  input  logic              ram_lsb_in,
  input  logic              ram_msb_in,
  input  logic              q_lsb_in,
  input  logic              q_msb_in,
  output logic [DATA_W-1:0] q,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] y_val,
  output logic              ram_lsb_oe,
  output logic              ram_lsb_o,
  output logic              ram_msb_oe,
  output logic              ram_msb_o,
  output logic              q_lsb_oe,
  output logic              q_lsb_o,
  output logic              q_msb_oe,
  output logic              q_msb_o
);
  localparam int MSB = DATA_W - 1;

  function automatic logic [MSB:0] shift_dn(logic [MSB:0] x, logic fill);
    return {fill, x[MSB:1]};
  endfunction

  function automatic logic [MSB:0] shift_up(logic [MSB:0] x, logic fill);
    return {x[MSB-1:0], fill};
  endfunction

  logic [MSB:0] q_nxt;
  logic         q_ld;
  logic         go_dn, go_up;

  always_comb begin
    q_ld    = 1'b0;
    q_nxt   = q;
    wr_en   = 1'b0;
    wr_data = f;
    case (dst_sel)
      DST_QREG:  begin q_ld = 1'b1; q_nxt = f; end
      DST_NOP:   ;
      DST_RAM_A,
      DST_RAM_F: wr_en = 1'b1;
      DST_DN_RQ: begin
        wr_en = 1'b1; wr_data = shift_dn(f, ram_msb_in);
        q_ld  = 1'b1; q_nxt   = shift_dn(q, q_msb_in);
      end
      DST_DN_R:  begin wr_en = 1'b1; wr_data = shift_dn(f, ram_msb_in); end
      DST_UP_RQ: begin
        wr_en = 1'b1; wr_data = shift_up(f, ram_lsb_in);
        q_ld  = 1'b1; q_nxt   = shift_up(q, q_lsb_in);
      end
      default:   begin wr_en = 1'b1; wr_data = shift_up(f, ram_lsb_in); end
    endcase
  end

  assign go_dn      = (dst_sel == DST_DN_RQ) || (dst_sel == DST_DN_R);
  assign go_up      = (dst_sel == DST_UP_RQ) || (dst_sel == DST_UP_R);
  assign ram_lsb_oe = go_dn;
  assign q_lsb_oe   = go_dn;
  assign ram_msb_oe = go_up;
  assign q_msb_oe   = go_up;
  assign ram_lsb_o  = f[0];
  assign q_lsb_o    = q[0];
  assign ram_msb_o  = f[MSB];
  assign q_msb_o    = q[MSB];
  assign y_val      = (dst_sel == DST_RAM_A) ? a_op : f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_ld) q <= q_nxt;
  end

  // R7
  q_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_sel == DST_NOP) |=> $stable(q));

  // R8
  q_shift_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_sel == DST_DN_RQ) |=> q == {$past(q_msb_in), $past(q[MSB:1])});

  // R9
  q_shift_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_sel == DST_UP_RQ) |=> q == {$past(q[MSB-1:0]), $past(q_lsb_in)});

  // R10
  pins_idle_chk: assert property (@(negedge clk) disable iff (!rst_n)
    !dst_sel[2] |-> !(ram_lsb_oe || ram_msb_oe || q_lsb_oe || q_msb_oe));

endmodule

// File: rtl/alu_slice16.sv
module alu_slice16
  import alu_slice_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [8:0]        instr,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [DATA_W-1:0] d_in,
  input  logic              cin,
  inout  wire               ram_lsb,
  inout  wire               ram_msb,
  inout  wire               q_lsb,
  inout  wire               q_msb,
  input  logic              out_en,
  output logic [DATA_W-1:0] y,
  output logic              cout,
  output logic              ovf,
  output logic              zero,
  output logic              neg
);
  src_sel_e          src_sel;
  alu_fn_e           fn_sel;
  dst_sel_e          dst_sel;
  logic [DATA_W-1:0] rd_a, rd_b, q_val, f_val, y_val, wr_data;
  logic              wr_en;
  alu_flags_t        flags;
  logic              rl_oe, rl_o, rm_oe, rm_o, ql_oe, ql_o, qm_oe, qm_o;

  assign src_sel = src_sel_e'(instr[2:0]);
  assign fn_sel  = alu_fn_e'(instr[5:3]);
  assign dst_sel = dst_sel_e'(instr[8:6]);

  alu_slice_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .addr_a(addr_a), .addr_b(addr_b),
    .wr_en(wr_en), .wr_data(wr_data), .rd_a(rd_a), .rd_b(rd_b)
  );

  alu_slice_alu #(.DATA_W(DATA_W)) u_alu (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .fn_sel(fn_sel),
    .a_op(rd_a), .b_op(rd_b), .q_op(q_val), .d_op(d_in), .cin(cin),
    .f(f_val), .flags(flags)
  );

  alu_slice_dest #(.DATA_W(DATA_W)) u_dst (
    .clk(clk), .rst_n(rst_n), .dst_sel(dst_sel), .f(f_val), .a_op(rd_a),
    .ram_lsb_in(ram_lsb), .ram_msb_in(ram_msb), .q_lsb_in(q_lsb), .q_msb_in(q_msb),
    .q(q_val), .wr_en(wr_en), .wr_data(wr_data), .y_val(y_val),
    .ram_lsb_oe(rl_oe), .ram_lsb_o(rl_o), .ram_msb_oe(rm_oe), .ram_msb_o(rm_o),
    .q_lsb_oe(ql_oe), .q_lsb_o(ql_o), .q_msb_oe(qm_oe), .q_msb_o(qm_o)
  );

  assign ram_lsb = rl_oe ? rl_o : 1'bz;
  assign ram_msb = rm_oe ? rm_o : 1'bz;
  assign q_lsb   = ql_oe ? ql_o : 1'bz;
  assign q_msb   = qm_oe ? qm_o : 1'bz;
  assign y       = out_en ? y_val : 'z;
  assign cout    = flags.cout;
  assign ovf     = flags.ovf;
  assign zero    = flags.zero;
  assign neg     = flags.neg;

  // R6
  zero_vs_y_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (out_en && dst_sel != DST_RAM_A && zero) |-> (y == '0));

endmodule

// File: tb/alu_slice16_bench.sv
module alu_slice16_bench;

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  dst;
    logic [2:0]  fn;
    logic [2:0]  src;
    logic [3:0]  a;
    logic [3:0]  b;
    logic [15:0] d;
    logic        c;
    logic [15:0] y;
    logic [3:0]  fl;   // {cout, ovf, zero, neg}
  } vec_t;

  localparam int NVEC = 18;
  localparam vec_t TBL [NVEC] = '{
    {4'd7,  3'd3, 3'd0, 3'd7, 4'd0, 4'd1, 16'h1234, 1'b0, 16'h1234, 4'b0000},
    {4'd7,  3'd3, 3'd0, 3'd7, 4'd0, 4'd2, 16'h8000, 1'b0, 16'h8000, 4'b0001},
    {4'd7,  3'd0, 3'd0, 3'd7, 4'd0, 4'd0, 16'h00FF, 1'b0, 16'h00FF, 4'b0000},
    {4'd11, 3'd1, 3'd0, 3'd1, 4'd1, 4'd2, 16'h0000, 1'b0, 16'h9234, 4'b0001},
    {4'd2,  3'd1, 3'd0, 3'd0, 4'd2, 4'd0, 16'h0000, 1'b0, 16'h80FF, 4'b0001},
    {4'd5,  3'd1, 3'd0, 3'd1, 4'd2, 4'd2, 16'h0000, 1'b0, 16'h0000, 4'b1110},
    {4'd5,  3'd1, 3'd0, 3'd5, 4'd1, 4'd0, 16'h7000, 1'b0, 16'h8234, 4'b0101},
    {4'd3,  3'd1, 3'd1, 3'd5, 4'd1, 4'd0, 16'h0001, 1'b1, 16'h1233, 4'b1000},
    {4'd3,  3'd1, 3'd2, 3'd5, 4'd1, 4'd0, 16'h0001, 1'b0, 16'hEDCC, 4'b0001},
    {4'd4,  3'd1, 3'd3, 3'd6, 4'd0, 4'd0, 16'h0F00, 1'b0, 16'h0FFF, 4'b0000},
    {4'd4,  3'd1, 3'd4, 3'd1, 4'd1, 4'd2, 16'h0000, 1'b0, 16'h0000, 4'b0010},
    {4'd4,  3'd1, 3'd5, 3'd6, 4'd0, 4'd0, 16'h00F0, 1'b0, 16'h000F, 4'b0000},
    {4'd7,  3'd1, 3'd6, 3'd2, 4'd0, 4'd0, 16'h0000, 1'b0, 16'h00FF, 4'b0000},
    {4'd4,  3'd1, 3'd7, 3'd4, 4'd1, 4'd0, 16'h0000, 1'b0, 16'hEDCB, 4'b0001},
    {4'd2,  3'd1, 3'd0, 3'd3, 4'd0, 4'd2, 16'h0000, 1'b1, 16'h8001, 4'b0001},
    {4'd6,  3'd2, 3'd0, 3'd7, 4'd1, 4'd3, 16'h5555, 1'b0, 16'h1234, 4'b0000},
    {4'd11, 3'd1, 3'd3, 3'd4, 4'd3, 4'd0, 16'h0000, 1'b0, 16'h5555, 4'b0000},
    {4'd11, 3'd1, 3'd3, 3'd4, 4'd1, 4'd0, 16'h0000, 1'b0, 16'h1234, 4'b0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  instr = 9'b001_000_000;
  logic [3:0]  addr_a = '0, addr_b = '0;
  logic [15:0] d_in = '0;
  logic        cin = 1'b0;
  logic        out_en = 1'b1;
  wire  [15:0] y;
  wire         cout, ovf, zero, neg;
  wire         ram_lsb, ram_msb, q_lsb, q_msb;
  logic        rl_drv = 0, rl_val = 0, rm_drv = 0, rm_val = 0;
  logic        ql_drv = 0, ql_val = 0, qm_drv = 0, qm_val = 0;
  int          total = 0, bad = 0;
  bit          finished = 0;

  always #10 clk = ~clk;

  assign ram_lsb = rl_drv ? rl_val : 1'bz;
  assign ram_msb = rm_drv ? rm_val : 1'bz;
  assign q_lsb   = ql_drv ? ql_val : 1'bz;
  assign q_msb   = qm_drv ? qm_val : 1'bz;
  pulldown pd_rl (ram_lsb);
  pulldown pd_rm (ram_msb);
  pulldown pd_ql (q_lsb);
  pulldown pd_qm (q_msb);
  for (genvar gi = 0; gi < 16; gi++) begin : g_ypd
    pulldown pd_y (y[gi]);
  end

  alu_slice16 u_alu_slice16 (
    .clk(clk), .rst_n(rst_n), .instr(instr), .addr_a(addr_a), .addr_b(addr_b),
    .d_in(d_in), .cin(cin), .ram_lsb(ram_lsb), .ram_msb(ram_msb),
    .q_lsb(q_lsb), .q_msb(q_msb), .out_en(out_en), .y(y),
    .cout(cout), .ovf(ovf), .zero(zero), .neg(neg)
  );

  function automatic string rname(logic [3:0] id);
    case (id)
      4'd2:  return "R2";
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic release_pins();
    rl_drv = 0; rm_drv = 0; ql_drv = 0; qm_drv = 0;
  endtask

  // drive just after a rising edge, return in the settled low phase
  task automatic apply(logic [2:0] dst, logic [2:0] fn, logic [2:0] src,
                       logic [3:0] a, logic [3:0] b, logic [15:0] d, logic c);
    @(posedge clk);
    #2;
    instr = {dst, fn, src}; addr_a = a; addr_b = b; d_in = d; cin = c;
    @(negedge clk);
    #5;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1: Q and registers cleared
    apply(3'd1, 3'd3, 3'd2, 4'd0, 4'd0, 16'h0, 1'b0);
    chk("R1 q after reset", y, 16'h0000);
    chk("R1 zero after reset", {15'd0, zero}, 16'd1);
    apply(3'd1, 3'd3, 3'd4, 4'd9, 4'd0, 16'h0, 1'b0);
    chk("R1 reg9 after reset", y, 16'h0000);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      apply(TBL[i].dst, TBL[i].fn, TBL[i].src, TBL[i].a, TBL[i].b, TBL[i].d, TBL[i].c);
      chk({rname(TBL[i].req), " y"}, y, TBL[i].y);
      chk("R5/R6 flags", {12'd0, cout, ovf, zero, neg}, {12'd0, TBL[i].fl});
    end

    // R8: shift down into register 4 and Q (Q = 00FF)
    release_pins(); rm_drv = 1; rm_val = 1; qm_drv = 1; qm_val = 0;
    apply(3'd4, 3'd0, 3'd7, 4'd0, 4'd4, 16'h0003, 1'b0);
    chk("R8 y", y, 16'h0003);
    chk("R8 ram_lsb out", {15'd0, ram_lsb}, 16'd1);
    chk("R8 q_lsb out", {15'd0, q_lsb}, 16'd1);
    apply(3'd1, 3'd3, 3'd2, 4'd0, 4'd0, 16'h0, 1'b0);
    release_pins();
    chk("R8 q shifted", y, 16'h007F);
    apply(3'd1, 3'd3, 3'd4, 4'd4, 4'd0, 16'h0, 1'b0);
    chk("R8 reg4 shifted", y, 16'h8001);

    // R8: register-only down shift, Q untouched
    rm_drv = 1; rm_val = 0; qm_drv = 1; qm_val = 1;
    apply(3'd5, 3'd0, 3'd7, 4'd0, 4'd6, 16'h0011, 1'b0);
    chk("R8 ram_lsb out code5", {15'd0, ram_lsb}, 16'd1);
    apply(3'd1, 3'd3, 3'd2, 4'd0, 4'd0, 16'h0, 1'b0);
    release_pins();
    chk("R8 q kept code5", y, 16'h007F);
    apply(3'd1, 3'd3, 3'd4, 4'd6, 4'd0, 16'h0, 1'b0);
    chk("R8 reg6 shifted", y, 16'h0008);

    // R9: shift up into register 5 and Q (Q = 007F)
    rl_drv = 1; rl_val = 1; ql_drv = 1; ql_val = 1;
    apply(3'd6, 3'd0, 3'd7, 4'd0, 4'd5, 16'h8001, 1'b0);
    chk("R9 ram_msb out", {15'd0, ram_msb}, 16'd1);
    chk("R9 q_msb out", {15'd0, q_msb}, 16'd0);
    apply(3'd1, 3'd3, 3'd2, 4'd0, 4'd0, 16'h0, 1'b0);
    release_pins();
    chk("R9 q shifted", y, 16'h00FF);
    apply(3'd1, 3'd3, 3'd4, 4'd5, 4'd0, 16'h0, 1'b0);
    chk("R9 reg5 shifted", y, 16'h0003);

    // R9: register-only up shift
    rl_drv = 1; rl_val = 0; ql_drv = 1; ql_val = 0;
    apply(3'd7, 3'd0, 3'd7, 4'd0, 4'd7, 16'hC000, 1'b0);
    chk("R9 ram_msb out code7", {15'd0, ram_msb}, 16'd1);
    apply(3'd1, 3'd3, 3'd2, 4'd0, 4'd0, 16'h0, 1'b0);
    release_pins();
    chk("R9 q kept code7", y, 16'h00FF);
    apply(3'd1, 3'd3, 3'd4, 4'd7, 4'd0, 16'h0, 1'b0);
    chk("R9 reg7 shifted", y, 16'h8000);

    // R10: no pin driven on codes 0..3 (pins pulled low; F ends are 1, Q0 is 1)
    apply(3'd1, 3'd0, 3'd7, 4'd0, 4'd0, 16'h8001, 1'b0);
    chk("R10 pins released", {12'd0, ram_lsb, ram_msb, q_lsb, q_msb}, 16'd0);
    apply(3'd3, 3'd0, 3'd7, 4'd0, 4'd8, 16'h8001, 1'b0);
    chk("R10 pins released code3", {12'd0, ram_lsb, ram_msb, q_lsb, q_msb}, 16'd0);

    // R12: output enable (released bus pulled low)
    out_en = 1'b0;
    apply(3'd1, 3'd0, 3'd7, 4'd0, 4'd0, 16'hFFFF, 1'b0);
    chk("R12 y released", y, 16'h0000);
    out_en = 1'b1;
    #1;
    chk("R12 y driven", y, 16'hFFFF);

    // R13: address move in low phase held until clock high
    apply(3'd1, 3'd3, 3'd4, 4'd1, 4'd0, 16'h0, 1'b0);
    chk("R13 before move", y, 16'h1234);
    #1 addr_a = 4'd3;
    #2;
    chk("R13 held while low", y, 16'h1234);
    @(posedge clk);
    #3;
    chk("R13 after clock high", y, 16'h5555);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule